// File: doc/BRIEF.md
# Epoch-Based Hill-Climbing Voltage/Frequency Level Controller

This block chooses the operating voltage/frequency level of one processor core, once per epoch, with the aim of driving down the energy-delay product (EDP). An external measurement unit presents the EDP of the epoch that just finished together with a one-cycle end-of-epoch strobe. The controller compares that figure against the value it recorded at the previous epoch boundary. A move that lowered EDP is repeated, a move that raised it is undone by stepping the other way, and a change smaller than a programmable dead band leaves the level alone.

Levels are indices 0 to LEVELS-1. With the default of nine levels, index k stands for 500 + 125·k MHz, so index 8 is the 1500 MHz top point. The level never moves by more than one index per epoch, and it never leaves the valid range: a request to move past either end is absorbed and the remembered direction is turned around. A one-cycle strobe reports every actual level change to the regulator sequencer downstream.

Top module: `dvfs_hill_climber`

## Requirements
- R1: While reset is held and directly after it, `level` is LEVELS-1 (8 by default), `dir_up` is 0 (down), `level_chg` is 0, and no previous EDP is stored.
- R2: `level` is constant except in the cycle after a clock edge that sampled `epoch_end` high. It always lies in 0..LEVELS-1, and index k means 500 + 125·k MHz.
- R3: The first epoch end after reset only stores the EDP and moves one level in the recorded direction. From reset this takes the level from 8 to 7.
- R4: If the new EDP is below the stored one by at least `dead_band`, the level moves one step in the same direction as the last move, and `dir_up` keeps that direction.
- R5: If the new EDP is not below the stored one and differs from it by at least `dead_band`, the level moves one step against the last direction, and `dir_up` flips. An equal EDP with `dead_band` of 0 counts as a degradation.
- R6: If the absolute EDP difference is below `dead_band`, the level and `dir_up` are left unchanged. The new EDP still becomes the stored reference.
- R7: Each move is exactly one index. No jump of two or more ever occurs.
- R8: A move requested above the top or below index 0 leaves the level unchanged, and `dir_up` is set to point back into range (down at the top, up at the bottom).
- R9: `level_chg` is high for exactly one cycle, in the same cycle that `level` shows its new value, and only when the index actually changed. Both update one clock after the sampled `epoch_end`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| epoch_end | input | 1 | One-cycle strobe marking the end of an epoch |
| edp_in | input | EDP_W | EDP measured for the epoch that just finished |
| dead_band | input | EDP_W | Minimum absolute EDP change that triggers a move |
| level | output | $clog2(LEVELS) | Current voltage/frequency level index |
| level_chg | output | 1 | One-cycle pulse when the level index changes |
| dir_up | output | 1 | Recorded direction: 1 = up, 0 = down |

## Verification
On every cycle the assertions check that the level stays in range, moves only after an epoch strobe and by one index at most, and that the change strobe matches exactly the cycles where the index differs from the cycle before. The choice of direction depends on the stored EDP history and cannot be seen in any single cycle. So repeat-on-improve, reverse-on-degrade, hold inside the dead band with the direction kept, the first-epoch step and the direction flip at both clamps are shown only by the bench's directed EDP sequences.

// File: rtl/dvfs_hill_climber.sv
module dvfs_hill_climber #(
  parameter int LEVELS = 9,
  parameter int EDP_W  = 16,
  localparam int LVL_W = $clog2(LEVELS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             epoch_end,
  input  logic [EDP_W-1:0] edp_in,
  input  logic [EDP_W-1:0] dead_band,
  output logic [LVL_W-1:0] level,
  output logic             level_chg,
  output logic             dir_up
);

  localparam logic [LVL_W-1:0] TOP = LVL_W'(LEVELS - 1);

  logic [EDP_W-1:0] prev_edp;
  logic             prev_ok;

  wire              better = edp_in < prev_edp;
  wire [EDP_W-1:0]  delta  = better ? prev_edp - edp_in : edp_in - prev_edp;
  wire              hold   = prev_ok && (delta < dead_band);
  wire              want_up = !prev_ok ? dir_up : (better ? dir_up : !dir_up);
  wire              at_top = level == TOP;
  wire              at_bot = level == '0;

  logic [LVL_W-1:0] nxt_level;
  logic             nxt_dir;

  always_comb begin
    nxt_level = level;
    nxt_dir   = dir_up;
    if (epoch_end && !hold) begin
      if (want_up) begin
        if (at_top) nxt_dir = 1'b0;
        else begin nxt_level = level + 1'b1; nxt_dir = 1'b1; end
      end else begin
        if (at_bot) nxt_dir = 1'b1;
        else begin nxt_level = level - 1'b1; nxt_dir = 1'b0; end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level     <= TOP;
      dir_up    <= 1'b0;
      level_chg <= 1'b0;
      prev_edp  <= '0;
      prev_ok   <= 1'b0;
    end else begin
      level     <= nxt_level;
      dir_up    <= nxt_dir;
      level_chg <= nxt_level != level;
      if (epoch_end) begin
        prev_edp <= edp_in;
        prev_ok  <= 1'b1;
      end
    end
  end

  a_r2_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    level <= TOP);

  a_r2_quiet_between_epochs: assert property (@(posedge clk) disable iff (!rst_n)
    !epoch_end |=> $stable(level));

  a_r7_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(level) |-> (level == $past(level) + 1'b1) || (level + 1'b1 == $past(level)));

  a_r9_strobe_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(level) |-> level_chg);

  a_r9_no_strobe_when_same: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(level) |-> !level_chg);

endmodule

// File: tb/tb_dvfs_hill_climber.sv
module tb_dvfs_hill_climber;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        epoch_end = 0;
  logic [15:0] edp_in = 0;
  logic [15:0] dead_band = 16'd10;
  logic [3:0]  level;
  logic        level_chg;
  logic        dir_up;
  int checks = 0;
  int errors = 0;

  dvfs_hill_climber dut (.clk(clk), .rst_n(rst_n), .epoch_end(epoch_end), .edp_in(edp_in),
    .dead_band(dead_band), .level(level), .level_chg(level_chg), .dir_up(dir_up));

  always #5 clk = ~clk;

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic epoch(input int v);
    @(negedge clk); epoch_end = 1; edp_in = 16'(v);
    @(negedge clk); epoch_end = 0;
  endtask

  task automatic expect_state(string req, int lv, int dir, int chg);
    chk(req, level, lv, "level");
    chk(req, dir_up, dir, "dir_up");
    chk(req, level_chg, chg, "level_chg");
  endtask

  task automatic do_reset();
    rst_n = 0; epoch_end = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    expect_state("R1", 8, 0, 0);
  endtask

  task automatic t_first_epoch();
    epoch(1000);
    expect_state("R3", 7, 0, 1);
    @(negedge clk);
    expect_state("R9", 7, 0, 0);
    repeat (4) @(negedge clk);
    chk("R2", level, 7, "level idle");
  endtask

  task automatic t_improve();
    epoch(900);
    expect_state("R4", 6, 0, 1);
  endtask

  task automatic t_degrade();
    epoch(950);
    expect_state("R5", 7, 1, 1);
  endtask

  task automatic t_hold_keeps_dir();
    epoch(955);
    expect_state("R6", 7, 1, 0);
    epoch(1100);
    expect_state("R6", 6, 0, 1);
  endtask

  task automatic t_clamp_bottom();
    for (int i = 0; i < 6; i++) begin
      epoch(1000 - 100 * i);
      chk("R7", level, 5 - i, "level walk down");
    end
    epoch(400);
    expect_state("R8", 0, 1, 0);
    epoch(300);
    expect_state("R8", 1, 1, 1);
  endtask

  task automatic t_clamp_top();
    do_reset();
    epoch(1000);
    expect_state("R3", 7, 0, 1);
    epoch(1200);
    expect_state("R5", 8, 1, 1);
    epoch(1100);
    expect_state("R8", 8, 0, 0);
    epoch(1000);
    expect_state("R4", 7, 0, 1);
  endtask

  task automatic t_equal_zero_band();
    dead_band = 0;
    epoch(1000);
    expect_state("R5", 8, 1, 1);
    dead_band = 16'd10;
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_first_epoch();
    t_improve();
    t_degrade();
    t_hold_keeps_dir();
    t_clamp_bottom();
    t_clamp_top();
    t_equal_zero_band();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule